// File: doc/BRIEF.md
# RTC Second Tick with Hourly Drift Compensation

This block divides a 32768 Hz clock-enable stream into a one-cycle strobe per second for a real-time clock. It holds a signed 16-bit compensation count and an auto-compensation enable. Both are reached through a small byte-wide register bus. When the calendar reports that the time sits exactly on the hour and auto-compensation is on, the next second is made longer or shorter by the compensation count. Over many hours this trims the drift of a crystal whose frequency is slightly off.

The length of each second is fixed at the clock edge that ends the previous second. At that edge the block samples the on-hour flag, the enable bit and the compensation value. Writes that arrive later do not change the second that has already started. The calendar logic that counts seconds and minutes, and drives the on-hour flag, sits outside this block.

Top module: `rtc_drift_tick`

## Requirements
- R1: After reset the compensation value is 0 and auto-compensation is off. No strobe is issued during reset. Reads of offsets 0x4C, 0x50 and 0x40 return 0.
- R2: A second without compensation lasts TICKS_PER_SEC sampled tick enables (32768 by default). `sec_strobe` is high for exactly one cycle, in the cycle after the edge that samples the final tick enable of the second.
- R3: Cycles with `tick_en` low do not advance the second. The length of a second counts only sampled tick enables, whatever their spacing.
- R4: The compensation value is 16 bits, two's complement. A write to offset 0x4C replaces bits 7:0 and a write to offset 0x50 replaces bits 15:8; the other byte keeps its value. A read of either offset returns the matching byte.
- R5: Offset 0x40 is the control byte, and its bit 2 is the auto-compensation enable. The other bits of a control write are discarded and read back as 0. Writes to any other offset change nothing, and reads of any other offset return 0.
- R6: If auto-compensation is on and `on_hour` is high at the edge that ends a second, the following second lasts TICKS_PER_SEC plus the signed compensation value in tick enables.
- R7: Compensation affects only that one second. The second after it is nominal again unless the conditions of R6 hold once more at its end.
- R8: If auto-compensation is off or `on_hour` is low at the edge that ends a second, the following second is nominal, whatever compensation value is stored.
- R9: A compensated length below 1 is clamped to 1 tick enable. With tick enables every cycle, strobes then come on consecutive cycles.
- R10: The length decision uses the register values held before the edge that ends the second. A write that lands on that same edge affects only later decisions, and writes made during a second leave that second's length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| on_hour | input | 1 | High while the calendar's seconds and minutes are both zero |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| sec_strobe | output | 1 | One-cycle pulse at the end of each second |

## Verification
A register write and the edge that ends a second can land in the same cycle. The block must then use the compensation value it held before that edge, and apply the new value only from the next decision on. The bench keeps the tick enable high every cycle, so the boundary edge falls on a known cycle. It times a compensation-byte write to hit that edge exactly, then checks the lengths of the next two seconds: the first must carry the old count and the second the new one. Random phases also write the registers in the middle of a second, and each measured length is compared with the bench model's value for the state that held at the boundary.

// File: rtl/rtc_comp_pkg.sv
// Package: shared constants for the drift-compensated second tick.
// Assumes byte-wide registers decoded on an 8-bit offset bus.
package rtc_comp_pkg;
    localparam int REG_W        = 8;
    localparam int OFS_CTRL     = 'h40;
    localparam int OFS_COMP_LO  = 'h4C;
    localparam int OFS_COMP_HI  = 'h50;
    localparam int CTRL_AUTO_BIT = 2;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_CTRL    = 2'd1,
        SEL_COMP_LO = 2'd2,
        SEL_COMP_HI = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/rtc_comp_regs.sv
// Module: rtc_comp_regs
// Holds the signed compensation value (two byte lanes) and the auto enable.
// Assumes single-cycle writes; reads are combinational from the offset.
module rtc_comp_regs
    import rtc_comp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int COMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [COMP_W-1:0] comp_val,
    output logic              auto_en
);
    localparam int LANES = COMP_W / REG_W;

    reg_sel_e sel;

    // Decode the offset into a register select.
    always_comb begin
        unique case (int'(reg_addr))
            OFS_CTRL:    sel = SEL_CTRL;
            OFS_COMP_LO: sel = SEL_COMP_LO;
            OFS_COMP_HI: sel = SEL_COMP_HI;
            default:     sel = SEL_NONE;
        endcase
    end

    // One flop group per byte lane of the compensation value.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam reg_sel_e LANE_SEL = (g == 0) ? SEL_COMP_LO : SEL_COMP_HI;
        logic [REG_W-1:0] lane_q;

        // Lane write: only its own select touches it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (reg_wr && sel == LANE_SEL)
                lane_q <= reg_wdata;
        end

        assign comp_val[g*REG_W +: REG_W] = lane_q;
    end

    // Auto-compensation enable, taken from one bit of the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            auto_en <= 1'b0;
        else if (reg_wr && sel == SEL_CTRL)
            auto_en <= reg_wdata[CTRL_AUTO_BIT];
    end

    // Read mux; unmapped offsets and unused control bits return zero.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL:    reg_rdata[CTRL_AUTO_BIT] = auto_en;
            SEL_COMP_LO: reg_rdata = comp_val[REG_W-1:0];
            SEL_COMP_HI: reg_rdata = comp_val[2*REG_W-1:REG_W];
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_len_calc.sv
// Module: rtc_len_calc
// Computes the length of the next second in tick enables.
// Assumes LEN_W is wide enough for nominal plus the largest positive count.
module rtc_len_calc #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int COMP_W        = 16,
    parameter int LEN_W         = 16
) (
    input  logic              apply,
    input  logic [COMP_W-1:0] comp_val,
    output logic [LEN_W-1:0]  next_len
);
    localparam int SUM_W = LEN_W + 1;
    localparam logic signed [SUM_W-1:0] NOM = SUM_W'(TICKS_PER_SEC);
    localparam logic signed [SUM_W-1:0] ONE = SUM_W'(1);

    logic signed [SUM_W-1:0] comp_ext;
    logic signed [SUM_W-1:0] sum;

    // Sign-extend the count and add it to the nominal length.
    always_comb begin
        comp_ext = {{(SUM_W-COMP_W){comp_val[COMP_W-1]}}, comp_val};
        sum      = NOM + comp_ext;
    end

    // Pick nominal or compensated length, clamping at one tick.
    always_comb begin
        if (!apply)
            next_len = NOM[LEN_W-1:0];
        else if (sum < ONE)
            next_len = ONE[LEN_W-1:0];
        else
            next_len = sum[LEN_W-1:0];
    end
endmodule

// File: rtl/rtc_sec_divider.sv
// Module: rtc_sec_divider
// Counts tick enables up to a per-second length and emits a one-cycle strobe.
// Assumes next_len is never zero; it is loaded at the edge ending a second.
module rtc_sec_divider #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEN_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [LEN_W-1:0] next_len,
    output logic             sec_strobe,
    output logic [LEN_W-1:0] period_len,
    output logic [LEN_W-1:0] tick_cnt
);
    localparam logic [LEN_W-1:0] NOM = LEN_W'(TICKS_PER_SEC);

    logic last_tick;

    // Final tick of the running second.
    always_comb last_tick = (tick_cnt == period_len - LEN_W'(1));

    // Counter, length latch and strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt   <= '0;
            period_len <= NOM;
            sec_strobe <= 1'b0;
        end else if (tick_en && last_tick) begin
            tick_cnt   <= '0;
            period_len <= next_len;
            sec_strobe <= 1'b1;
        end else begin
            sec_strobe <= 1'b0;
            if (tick_en)
                tick_cnt <= tick_cnt + LEN_W'(1);
        end
    end
endmodule

// File: rtl/rtc_drift_tick.sv
// Module: rtc_drift_tick (top)
// One-second tick from a 32768 Hz enable with hourly signed trim.
// Assumes on_hour comes from the calendar and is stable at second boundaries.
module rtc_drift_tick
    import rtc_comp_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int COMP_W        = 16,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              on_hour,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              sec_strobe
);
    localparam int LEN_W = $clog2(TICKS_PER_SEC + 2**(COMP_W-1));

    logic [COMP_W-1:0] comp_val;
    logic              auto_en;
    logic              apply;
    logic [LEN_W-1:0]  next_len;
    logic [LEN_W-1:0]  period_len;
    logic [LEN_W-1:0]  tick_cnt;

    rtc_comp_regs #(.ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .comp_val(comp_val), .auto_en(auto_en)
    );

    // Trim applies only when enabled and the calendar is on the hour.
    always_comb apply = auto_en & on_hour;

    rtc_len_calc #(.TICKS_PER_SEC(TICKS_PER_SEC), .COMP_W(COMP_W), .LEN_W(LEN_W)) u_len (
        .apply(apply), .comp_val(comp_val), .next_len(next_len)
    );

    rtc_sec_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .LEN_W(LEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .next_len(next_len),
        .sec_strobe(sec_strobe), .period_len(period_len), .tick_cnt(tick_cnt)
    );
endmodule

// File: rtl/rtc_drift_tick_chk.sv
// Module: rtc_drift_tick_chk
// Temporal checks on the second tick; bound into every rtc_drift_tick.
module rtc_drift_tick_chk #(
    parameter int ADDR_W = 8,
    parameter int COMP_W = 16,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              sec_strobe,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [COMP_W-1:0] comp_val,
    input logic              auto_en,
    input logic [LEN_W-1:0]  period_len,
    input logic [LEN_W-1:0]  tick_cnt
);
    // R1: reset clears the stored state and the strobe
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (comp_val == '0 && !auto_en && !sec_strobe));

    // R2: a strobe only follows a sampled tick enable
    a_r2_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |-> $past(tick_en));

    // R3: idle cycles neither count nor strobe
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(tick_cnt) && !sec_strobe));

    // R4: a low-byte write keeps the high byte
    a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_addr) == 'h4C) |=> comp_val[COMP_W-1:8] == $past(comp_val[COMP_W-1:8]));

    // R4: a high-byte write keeps the low byte
    a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_addr) == 'h50) |=> comp_val[7:0] == $past(comp_val[7:0]));

    // R9: the second length is never zero
    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        period_len != '0);

    // R10: the length only changes at a second boundary
    a_r10_len_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(period_len) |-> sec_strobe);
endmodule

bind rtc_drift_tick rtc_drift_tick_chk #(.ADDR_W(ADDR_W), .COMP_W(COMP_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sec_strobe(sec_strobe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .comp_val(comp_val), .auto_en(auto_en),
    .period_len(period_len), .tick_cnt(tick_cnt)
);

// File: tb/rtc_drift_tick_tb.sv
module rtc_drift_tick_tb;
    localparam int TPS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       on_hour = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sec_strobe;

    int errors = 0;
    int checks = 0;
    int n_sec = 0;
    int len_log [256];
    int tick_mode = 0;      // 0: every cycle, 1: ~50 %, 2: sparse
    bit done = 0;

    bit       m_auto = 0;
    int       m_comp = 0;

    rtc_drift_tick #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .on_hour(on_hour),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sec_strobe(sec_strobe)
    );

    always #4 clk = ~clk;

    function automatic int exp_len(bit a, bit oh, int c);
        int v;
        if (!(a && oh)) return TPS;
        v = TPS + c;
        return (v < 1) ? 1 : v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(int a, int exp, string req);
        reg_addr = 8'(a);
        #1;
        check(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
    endtask

    task automatic set_comp(int c);
        wr('h4C, c & 'hFF);
        wr('h50, (c >> 8) & 'hFF);
        m_comp = c;
    endtask

    task automatic wait_sec(int target);
        wait (n_sec >= target);
    endtask

    // Monitor and tick driver: measures each second in sampled tick enables.
    initial begin
        int cnt = 0;
        bit last_te = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cnt = 0; last_te = 0; tick_en = 1'b0;
            end else begin
                if (last_te) cnt++;
                if (sec_strobe) begin
                    len_log[n_sec % 256] = cnt;
                    cnt = 0;
                    n_sec++;
                end
                case (tick_mode)
                    0: tick_en = 1'b1;
                    1: tick_en = ($urandom_range(1, 0) == 1);
                    default: tick_en = ($urandom_range(3, 0) == 0);
                endcase
                last_te = tick_en;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sec_strobe == 1'b0, "R1 strobe in reset", int'(sec_strobe), 0);
        rd_check('h4C, 0, "R1 comp lo");
        rd_check('h50, 0, "R1 comp hi");
        rd_check('h40, 0, "R1 ctrl");
        @(negedge clk);
        rst_n = 1'b1;

        // R4: byte lanes independent
        wr('h4C, 'h34);
        wr('h50, 'h12);
        rd_check('h4C, 'h34, "R4 lo readback");
        rd_check('h50, 'h12, "R4 hi readback");
        wr('h4C, 'hAB);
        rd_check('h50, 'h12, "R4 hi kept");
        rd_check('h4C, 'hAB, "R4 lo new");
        // R5: control bits and unmapped offsets
        wr('h40, 'hFF);
        rd_check('h40, 'h04, "R5 ctrl only auto bit");
        wr('h40, 'h00);
        rd_check('h40, 0, "R5 ctrl cleared");
        wr('h44, 'h5A);
        rd_check('h44, 0, "R5 unmapped read");
        rd_check('h4C, 'hAB, "R5 unmapped write no effect lo");
        rd_check('h50, 'h12, "R5 unmapped write no effect hi");
        m_comp = 'h12AB;

        // R2: first second nominal
        wait_sec(2);
        check(len_log[0] == TPS, "R2 first second", len_log[0], TPS);
        check(len_log[1] == TPS, "R2 second second", len_log[1], TPS);

        // R8: on_hour with auto off -> nominal
        on_hour = 1'b1;
        s = n_sec;
        wait_sec(s + 2);
        check(len_log[s + 1] == TPS, "R8 auto off", len_log[s + 1], TPS);

        // R6/R7 and R10: write landing on the boundary edge
        on_hour = 1'b0;
        set_comp(10);
        wr('h40, 'h04); m_auto = 1;
        wait_sec(n_sec + 2);
        s = n_sec;
        on_hour = 1'b1;               // decision at end of second s
        wait_sec(s + 1);              // now inside second s+1 (length 74)
        repeat (TPS + 10 - 1) @(negedge clk);
        wr('h4C, 20);                 // sampled on the edge ending s+1
        m_comp = 20;
        wait_sec(s + 3);
        on_hour = 1'b0;
        wait_sec(s + 5);
        check(len_log[s] == TPS, "R8 before on_hour", len_log[s], TPS);
        check(len_log[s + 1] == TPS + 10, "R6 compensated", len_log[s + 1], TPS + 10);
        check(len_log[s + 2] == TPS + 10, "R10 old value at boundary", len_log[s + 2], TPS + 10);
        check(len_log[s + 3] == TPS + 20, "R10 new value later", len_log[s + 3], TPS + 20);
        check(len_log[s + 4] == TPS, "R7 back to nominal", len_log[s + 4], TPS);

        // R9: clamp to one tick, back-to-back strobes
        set_comp(-100);
        wait_sec(n_sec + 1);
        s = n_sec;
        on_hour = 1'b1;
        wait_sec(s + 3);
        on_hour = 1'b0;
        wait_sec(s + 5);
        check(len_log[s + 1] == 1, "R9 clamp", len_log[s + 1], 1);
        check(len_log[s + 2] == 1, "R9 clamp repeat", len_log[s + 2], 1);
        check(len_log[s + 3] == 1, "R9 clamp last", len_log[s + 3], 1);
        check(len_log[s + 4] == TPS, "R7 after clamp", len_log[s + 4], TPS);

        // Random phase: R3 gated ticks, R6/R8 mixed state
        for (int it = 0; it < 24; it++) begin
            int c;
            int e;
            tick_mode = int'($urandom_range(2, 0));
            s = n_sec;
            c = int'($urandom_range(250, 0)) - 50;
            set_comp(c);
            m_auto = ($urandom_range(1, 0) == 1);
            wr('h40, m_auto ? 'h04 : 'h00);
            on_hour = ($urandom_range(1, 0) == 1);
            e = exp_len(m_auto, on_hour, m_comp);
            wait_sec(s + 2);
            check(len_log[(s + 1) % 256] == e,
                  (m_auto && on_hour) ? "R6 random" : (tick_mode != 0 ? "R3 random" : "R8 random"),
                  len_log[(s + 1) % 256], e);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule